// File: doc/BRIEF.md
# Receive fabric width converter

This block sits at the end of a receive lane. Each lane clock cycle it takes one internal word that has already been decoded. It packs one, two or four of these words into a wider word for user logic, and it also generates the slower user clock that goes with the wider word. A 4-bit mode code fixes how wide the internal word is and which output widths are allowed. A 2-bit width selector sets the packing ratio.

Packing happens in the lane clock domain. Each finished wide word then passes through a small Gray-pointer FIFO into the user clock domain, which takes up the phase offset between the two clocks. The output stays quiet until the FIFO holds two entries. After that it delivers one packed word every user clock. Both configuration inputs are static: they may change only while reset is asserted.

Top module: `rx_width_conv`

## Requirements
- R1: The legal settings are: mode 4'b0111, 4'b1010 or 4'b1011 with width selector 0, 1 or 2, and mode 4'b0001 with selector 0. Any other pair drives `cfg_err_o` high, and in that case `valid_o` never rises.
- R2: `usr_clk_o` runs at the lane clock rate divided by 1, 2 or 4 for width selector 0, 1 or 2 (ratio R = 2^selector).
- R3: Each mode takes a fixed slice of `word_i` per internal word: bits [15:0] for 4'b0111 and 4'b1010, bits [19:0] for 4'b1011, and bits [63:0] for 4'b0001. All other input bits are ignored.
- R4: R consecutive internal words form one output word. Word i of the group (i = 0 first received) lands in bits [i*E +: E], where E is the slice width from R3. All output bits above R*E are zero.
- R5: Mode 4'b0001 is a 1:1 passthrough: each 64-bit input word appears unchanged in `data_o[63:0]`.
- R6: `valid_o` stays low after reset until the FIFO has two entries. This is no earlier than 2*R lane cycles after reset release. From then on it is high on every user clock, and the packed words come out in arrival order with none lost or repeated.
- R7: The crossing FIFO holds 8 entries and uses Gray-coded pointers with two-stage synchronizers. `overflow_o` and `underflow_o` are sticky and are cleared only by reset. Neither is ever set while a legal configuration is held static.
- R8: While reset is asserted, `valid_o`, `overflow_o` and `underflow_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_clk_i | input | 1 | Internal lane clock, one word per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Data mode code (static) |
| wsel_i | input | 2 | Width selector: 0 = x1, 1 = x2, 2 = x4 (static) |
| word_i | input | 64 | Internal word, valid every lane cycle |
| usr_clk_o | output | 1 | Divided user clock |
| data_o | output | 80 | Packed external word (user domain) |
| valid_o | output | 1 | `data_o` holds a new word (user domain) |
| cfg_err_o | output | 1 | Mode/width pair is not legal |
| overflow_o | output | 1 | Sticky: a write found the FIFO full |
| underflow_o | output | 1 | Sticky: the FIFO ran dry after priming |

## Verification
The FIFO assertions assume that the lane delivers a word on every lane clock and that mode and width stay fixed between resets. Under those conditions the write rate exactly matches the user-clock read rate, so no overflow or underflow is possible. The stimulus meets both assumptions: it applies a new word on every lane cycle and changes the configuration only while reset is held. The data fields carry an incrementing count under random noise from a fixed seed, so the noise checks the masking of unused bits. Each legal pair is run directed, a few legal pairs are then picked at random, and three illegal pairs are run to check the error path.

// File: rtl/rx_wc_pkg.sv
package rx_wc_pkg;
  localparam logic [3:0] MODE_8B10B = 4'b0111;
  localparam logic [3:0] MODE_6466  = 4'b0001;
  localparam logic [3:0] MODE_RAW16 = 4'b1010;
  localparam logic [3:0] MODE_RAW20 = 4'b1011;

  localparam int CNT_W  = 2;  // log2 of largest pack ratio
  localparam int WSEL_W = 2;

  function automatic logic cfg_legal(logic [3:0] mode, logic [WSEL_W-1:0] wsel);
    case (mode)
      MODE_8B10B, MODE_RAW16, MODE_RAW20: return int'(wsel) <= CNT_W;
      MODE_6466:                          return wsel == '0;
      default:                            return 1'b0;
    endcase
  endfunction

  function automatic int elem_w(logic [3:0] mode);
    case (mode)
      MODE_RAW20: return 20;
      MODE_6466:  return 64;
      default:    return 16;
    endcase
  endfunction
endpackage

// File: rtl/rx_wc_clkgen.sv
module rx_wc_clkgen
  import rx_wc_pkg::*;
(
  input  logic              lane_clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WSEL_W-1:0] wsel_i,
  output logic [CNT_W-1:0]  slot_o,
  output logic              last_o,
  output logic              usr_clk_o
);
  logic [CNT_W-1:0] cnt_q, last_slot;
  logic [CNT_W:0]   tap;

  assign last_slot = CNT_W'((1 << wsel_i) - 1);
  assign last_o    = (cnt_q == last_slot);
  assign slot_o    = cnt_q;

  always_ff @(posedge lane_clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || last_o)    cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // tap[0] = lane clock (x1), tap[k] = counter bit k-1 (divide by 2^k)
  assign tap       = {cnt_q, lane_clk_i};
  assign usr_clk_o = (int'(wsel_i) > CNT_W) ? 1'b0 : tap[wsel_i];

  a_r2_div2_toggle: assert property (@(posedge lane_clk_i) disable iff (!rst_ni)
    (en_i && wsel_i == 2'd1) |=> (usr_clk_o != $past(usr_clk_o)));
endmodule

// File: rtl/rx_wc_packer.sv
module rx_wc_packer
  import rx_wc_pkg::*;
#(
  parameter int IN_W  = 64,
  parameter int OUT_W = 80
) (
  input  logic             lane_clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [3:0]       mode_i,
  input  logic [CNT_W-1:0] slot_i,
  input  logic             last_i,
  input  logic [IN_W-1:0]  word_i,
  output logic             wr_o,
  output logic [OUT_W-1:0] wdata_o
);
  logic [IN_W-1:0]  mask;
  logic [OUT_W-1:0] acc_q, merged;
  int               ew, shamt;

  always_comb begin
    ew     = elem_w(mode_i);
    mask   = (ew >= IN_W) ? '1 : ((IN_W'(1) << ew) - IN_W'(1));
    shamt  = int'(slot_i) * ew;
    merged = ((slot_i == '0) ? '0 : acc_q) | (OUT_W'(word_i & mask) << shamt);
  end

  always_ff @(posedge lane_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      wr_o    <= 1'b0;
      wdata_o <= '0;
    end else begin
      wr_o <= en_i && last_i;
      if (en_i) begin
        acc_q <= merged;
        if (last_i) wdata_o <= merged;
      end
    end
  end

  // a completed group is always followed by slot 0 of the next group
  a_r4_pack_wrap: assert property (@(posedge lane_clk_i) disable iff (!rst_ni)
    wr_o |-> (slot_i == '0));
endmodule

// File: rtl/rx_wc_cdc_fifo.sv
module rx_wc_cdc_fifo #(
  parameter int W     = 80,
  parameter int DEPTH = 8,
  parameter int PRIME = 2,
  parameter int SYNC  = 2
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         rvalid_o,
  output logic         ovf_o,
  output logic         unf_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] b2g(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rsync_q [SYNC];
  logic [PW-1:0] wsync_q [SYNC];
  logic [PW-1:0] occ_w, occ_r;
  logic          full, started_q, rd;

  // write domain
  assign occ_w = wbin_q - g2b(rsync_q[SYNC-1]);
  assign full  = (occ_w == PW'(DEPTH));

  always_ff @(posedge wclk_i) begin
    if (wr_i && !full) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_o   <= 1'b0;
      for (int i = 0; i < SYNC; i++) rsync_q[i] <= '0;
    end else begin
      rsync_q[0] <= rgray_q;
      for (int i = 1; i < SYNC; i++) rsync_q[i] <= rsync_q[i-1];
      if (wr_i && !full) begin
        wbin_q  <= wbin_q + 1'b1;
        wgray_q <= b2g(wbin_q + 1'b1);
      end
      if (wr_i && full) ovf_o <= 1'b1;
    end
  end

  // read domain
  assign occ_r = g2b(wsync_q[SYNC-1]) - rbin_q;
  assign rd    = started_q && (occ_r != '0);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q    <= '0;
      rgray_q   <= '0;
      started_q <= 1'b0;
      rvalid_o  <= 1'b0;
      rdata_o   <= '0;
      unf_o     <= 1'b0;
      for (int i = 0; i < SYNC; i++) wsync_q[i] <= '0;
    end else begin
      wsync_q[0] <= wgray_q;
      for (int i = 1; i < SYNC; i++) wsync_q[i] <= wsync_q[i-1];
      if (occ_r >= PW'(PRIME)) started_q <= 1'b1;
      rvalid_o <= rd;
      if (rd) begin
        rdata_o <= mem[rbin_q[AW-1:0]];
        rbin_q  <= rbin_q + 1'b1;
        rgray_q <= b2g(rbin_q + 1'b1);
      end
      if (started_q && occ_r == '0) unf_o <= 1'b1;
    end
  end

  a_r7_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !(wr_i && full));
  a_r7_no_underflow: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    started_q |-> (occ_r != '0));
  a_r7_gray_step: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/rx_width_conv.sv
module rx_width_conv
  import rx_wc_pkg::*;
#(
  parameter int IN_W  = 64,
  parameter int OUT_W = 80,
  parameter int DEPTH = 8,
  parameter int PRIME = 2
) (
  input  logic             lane_clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       mode_i,
  input  logic [1:0]       wsel_i,
  input  logic [IN_W-1:0]  word_i,
  output logic             usr_clk_o,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o,
  output logic             cfg_err_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  logic             legal, last, wr, fifo_valid;
  logic [CNT_W-1:0] slot;
  logic [OUT_W-1:0] wdata;

  assign legal     = cfg_legal(mode_i, wsel_i);
  assign cfg_err_o = !legal;
  assign valid_o   = fifo_valid && legal;

  rx_wc_clkgen u_clkgen (
    .lane_clk_i (lane_clk_i),
    .rst_ni     (rst_ni),
    .en_i       (legal),
    .wsel_i     (wsel_i),
    .slot_o     (slot),
    .last_o     (last),
    .usr_clk_o  (usr_clk_o)
  );

  rx_wc_packer #(.IN_W(IN_W), .OUT_W(OUT_W)) u_packer (
    .lane_clk_i (lane_clk_i),
    .rst_ni     (rst_ni),
    .en_i       (legal),
    .mode_i     (mode_i),
    .slot_i     (slot),
    .last_i     (last),
    .word_i     (word_i),
    .wr_o       (wr),
    .wdata_o    (wdata)
  );

  rx_wc_cdc_fifo #(.W(OUT_W), .DEPTH(DEPTH), .PRIME(PRIME), .SYNC(2)) u_fifo (
    .wclk_i   (lane_clk_i),
    .rclk_i   (usr_clk_o),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .wdata_i  (wdata),
    .rdata_o  (data_o),
    .rvalid_o (fifo_valid),
    .ovf_o    (overflow_o),
    .unf_o    (underflow_o)
  );
endmodule

// File: tb/sim_rx_width_conv.sv
module sim_rx_width_conv;
  localparam int OUTS = 24;

  logic        lane_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = 4'b0111;
  logic [1:0]  wsel = 2'd0;
  logic [63:0] word = '0;
  logic        usr_clk, valid, cfg_err, ovf, unf;
  logic [79:0] data;

  always #4 lane_clk = ~lane_clk;  // 125 MHz

  rx_width_conv u0 (
    .lane_clk_i (lane_clk), .rst_ni (rst_n), .mode_i (mode), .wsel_i (wsel),
    .word_i (word), .usr_clk_o (usr_clk), .data_o (data), .valid_o (valid),
    .cfg_err_o (cfg_err), .overflow_o (ovf), .underflow_o (unf)
  );

  int checks = 0, fails = 0;
  logic [63:0] drv [256];
  int  ratio = 1, nout = 0, lcnt = 0, ucnt = 0, wd = 0;
  bit  coll = 1'b0, seen = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int ew_of(logic [3:0] m);
    if (m == 4'b1011) return 20;
    if (m == 4'b0001) return 64;
    return 16;
  endfunction

  function automatic logic [79:0] exp_word(int idx);
    logic [79:0] r = '0;
    int e = ew_of(mode);
    logic [63:0] msk = (e == 64) ? '1 : ((64'd1 << e) - 64'd1);
    for (int i = 0; i < ratio; i++) r |= 80'(drv[idx*ratio + i] & msk) << (i * e);
    return r;
  endfunction

  always @(posedge lane_clk) begin
    lcnt++;
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL R6 watchdog act=%0d exp=%0d", wd, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(posedge usr_clk) ucnt++;

  // output sampling away from the user clock rising edge
  always @(negedge usr_clk) begin
    if (coll) begin
      if (valid) begin
        if (cfg_err) chk(1'b0, "R1", "valid with bad config", 80'(valid), 80'd0);
        if (!seen) begin
          seen = 1'b1;
          chk(lcnt >= 2 * ratio, "R6", "priming too early", 80'(lcnt), 80'(2 * ratio));
        end
        if (nout < OUTS)
          chk(data == exp_word(nout), (mode == 4'b0001) ? "R5" : "R3 R4",
              "packed word", data, exp_word(nout));
        nout++;
      end else if (seen) begin
        chk(1'b0, "R6", "gap in valid stream", 80'(nout), 80'(nout + 1));
      end
    end
  end

  task automatic run_cfg(logic [3:0] m, logic [1:0] s, bit legal);
    int n, u0c;
    logic [31:0] base;
    coll = 1'b0;
    rst_n = 1'b0;
    mode = m;
    wsel = s;
    ratio = 1 << s;
    base = $urandom();
    for (int i = 0; i < 256; i++) drv[i] = {$urandom(), base + 32'(i)};
    word = drv[0];
    repeat (3) @(negedge lane_clk);
    chk(valid == 1'b0, "R8", "valid in reset", 80'(valid), 80'd0);
    chk(ovf == 1'b0, "R8", "overflow in reset", 80'(ovf), 80'd0);
    chk(unf == 1'b0, "R8", "underflow in reset", 80'(unf), 80'd0);
    chk(cfg_err == !legal, "R1", "cfg_err level", 80'(cfg_err), 80'(!legal));
    nout = 0;
    seen = 1'b0;
    lcnt = 0;
    coll = 1'b1;
    rst_n = 1'b1;
    n = legal ? (OUTS + 12) * ratio + 16 : 60;
    u0c = 0;
    for (int c = 1; c <= n; c++) begin
      @(negedge lane_clk);
      word = drv[c];
      if (c == 8) u0c = ucnt;
      if (c == 40 && legal)
        chk(ucnt - u0c == 32 / ratio, "R2", "user clock edges in 32 lane cycles",
            80'(ucnt - u0c), 80'(32 / ratio));
    end
    coll = 1'b0;
    if (legal) begin
      chk(nout >= OUTS, "R6", "output count", 80'(nout), 80'(OUTS));
      chk(ovf == 1'b0, "R7", "overflow flag", 80'(ovf), 80'd0);
      chk(unf == 1'b0, "R7", "underflow flag", 80'(unf), 80'd0);
    end else begin
      chk(nout == 0, "R1", "outputs under bad config", 80'(nout), 80'd0);
    end
  endtask

  initial begin
    logic [3:0] lm [10] = '{4'b0111, 4'b0111, 4'b0111, 4'b1010, 4'b1010, 4'b1010,
                            4'b1011, 4'b1011, 4'b1011, 4'b0001};
    logic [1:0] ls [10] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd2, 2'd0};
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 10; i++) run_cfg(lm[i], ls[i], 1'b1);
    run_cfg(4'b0001, 2'd1, 1'b0);
    run_cfg(4'b0000, 2'd0, 1'b0);
    run_cfg(4'b0111, 2'd3, 1'b0);
    for (int i = 0; i < 4; i++) begin
      int p = $urandom_range(0, 9);
      run_cfg(lm[p], ls[p], 1'b1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule